// File: doc/BRIEF.md
# Hybrid Coherence Line State Controller

This block keeps the coherence state of every line of a small private cache whose lines belong to one of two domains. In the hardware domain a line follows an invalid/shared/modified protocol and talks to a directory through read-request, write-request, write-release and read-release messages. In the software domain no directory message is ever sent. Software makes data visible itself: an invalidate drops the local copy, and a flush writes back only the words that stores have dirtied. A 16-entry region table holds one bit per naturally aligned 4 KiB region and says which domain the region is in. Every entry resets to the hardware domain. Software rewrites the table at run time, and a line changes domain in place the next time it is touched.

The core presents one request at a time (load, read-only load, store, invalidate or flush) together with the line's slot, word and region index, and holds it until `req_ready`. Line states are HW-Invalid, HW-Shared, HW-Modified, SW-Clean, SW-Immutable, SW-PrivClean and SW-PrivDirty. The request sequencer has three states: IDLE, WAIT_FILL and WAIT_REL.

In IDLE, a line whose domain disagrees with the table is moved first. HW-Modified sends a write release and HW-Shared sends a read release, both going to WAIT_REL. HW-Invalid becomes SW-Clean directly. Any software state sends a read release (with a write-back of dirty words if SW-PrivDirty) and goes to WAIT_REL. A hardware load miss or a store without ownership goes to WAIT_FILL. A grant in WAIT_FILL completes the request; a grant in WAIT_REL returns to IDLE, which then serves the request in its new domain.

Top module: `hybrid_coh_ctrl`

## Requirements
- R1: After reset every line is HW-Invalid, every region is hardware-domain, and dir_valid, wb_valid and req_ready are low while no request is presented; the first load to any line therefore issues a read request.
- R2: A load (req_op 0) or read-only load (req_op 1) in the hardware domain to an Invalid line issues dir_op 0 (read request) and completes on the grant with rsp_hit 0, leaving the line Shared. A load to a Shared or Modified line completes at once with rsp_hit 1 and no message.
- R3: A store (req_op 2) in the hardware domain to an Invalid or Shared line issues dir_op 1 (write request) and completes on the grant with rsp_hit 0, leaving the line Modified. A store to a Modified line completes at once with rsp_hit 1.
- R4: Only one directory message is outstanding. From dir_valid until dir_gnt, req_ready and dir_valid stay low.
- R5: In the software domain a load to SW-Clean completes with rsp_hit 0 and moves the line to SW-PrivClean. A read-only load to SW-Clean moves it to SW-Immutable. Loads to any other software state hit. No directory message is issued.
- R6: A software-domain store to SW-Clean (rsp_hit 0), SW-PrivClean or SW-PrivDirty (rsp_hit 1) moves the line to SW-PrivDirty and sets bit req_word of its dirty mask. A store to SW-Immutable completes with rsp_err 1 and changes nothing.
- R7: A flush (req_op 4) of a SW-PrivDirty line raises wb_valid for one cycle, with wb_mask equal to the set of words stored since the line was last clean, and leaves the line SW-Clean. A flush of any other software state writes nothing back.
- R8: An invalidate (req_op 3) in the software domain leaves the line SW-Clean and discards its dirty words without write-back.
- R9: When the table marks a hardware-domain line's region as software (tbl_sw 1), the next access first releases the line. Modified sends dir_op 2 (write release), Shared sends dir_op 3 (read release), and Invalid sends nothing. The line then becomes SW-Clean and the access is served in the software domain.
- R10: When a software-domain line's region is returned to hardware, the next access sends dir_op 3. If the line is SW-PrivDirty, the same cycle carries wb_valid with its dirty words. After the grant the line is HW-Invalid and the access continues under R2 or R3.
- R11: A table write (tbl_we, tbl_idx, tbl_sw) takes effect for requests presented from the following cycle on.
- R12: Invalidate and flush in the hardware domain complete at once, with no message, no write-back and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented, held until req_ready |
| req_op | input | 3 | 0 load, 1 read-only load, 2 store, 3 invalidate, 4 flush |
| req_region | input | 4 | Region table index of the line's address |
| req_slot | input | 2 | Cache line slot |
| req_word | input | 2 | Word within the line |
| req_ready | output | 1 | Request completes this cycle |
| rsp_hit | output | 1 | Completed access had the needed permission |
| rsp_err | output | 1 | Store to an immutable line, not performed |
| dir_valid | output | 1 | Directory message valid (one cycle) |
| dir_op | output | 2 | 0 read req, 1 write req, 2 write release, 3 read release |
| dir_gnt | input | 1 | Directory grant for the outstanding message |
| msg_slot | output | 2 | Slot the message or write-back refers to |
| wb_valid | output | 1 | Write-back of dirty words this cycle |
| wb_mask | output | 4 | Words written back |
| tbl_we | input | 1 | Region table write strobe |
| tbl_idx | input | 4 | Region table entry to write |
| tbl_sw | input | 1 | 1 software domain, 0 hardware domain |

## Verification
The hardest state to reach from the ports is a SW-PrivDirty line with several scattered dirty words whose region is then moved back to the hardware domain. That access must combine a write-back of exactly those words with a read release, and after the grant it must also issue a fresh read request. The bench gets there by flipping a region to software, storing to chosen words, and flipping the region back before the next load. A long pseudo-random sweep over four slots, two regions, all five operations and interleaved table writes then compares every access with an arithmetic model of the states.

// File: rtl/hcoh_pkg.sv
package hcoh_pkg;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_LOAD_RO = 3'd1,
        OP_STORE   = 3'd2,
        OP_INV     = 3'd3,
        OP_FLUSH   = 3'd4
    } core_op_e;

    typedef enum logic [1:0] {
        DIR_RDREQ = 2'd0,
        DIR_WRREQ = 2'd1,
        DIR_WRREL = 2'd2,
        DIR_RDREL = 2'd3
    } dir_op_e;

    typedef enum logic [2:0] {
        LN_HW_INV   = 3'd0,
        LN_HW_SHR   = 3'd1,
        LN_HW_MOD   = 3'd2,
        LN_SW_CLEAN = 3'd4,
        LN_SW_IMM   = 3'd5,
        LN_SW_PCLN  = 3'd6,
        LN_SW_PDRT  = 3'd7
    } line_st_e;

    function automatic logic in_sw_domain(line_st_e s);
        return s inside {LN_SW_CLEAN, LN_SW_IMM, LN_SW_PCLN, LN_SW_PDRT};
    endfunction

endpackage

// File: rtl/hcoh_region_tbl.sv
module hcoh_region_tbl #(
    parameter int NUM_REGIONS = 16,
    parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_sw,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_sw
);
    logic [NUM_REGIONS-1:0] sw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (wr_en) begin
            sw_q[wr_idx] <= wr_sw;
        end
    end

    assign rd_sw = sw_q[rd_idx];
endmodule

// File: rtl/hcoh_line_store.sv
module hcoh_line_store
    import hcoh_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int WORDS     = 4,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    output line_st_e          rd_state,
    output logic [WORDS-1:0]  rd_dirty,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              st_we,
    input  line_st_e          st_new,
    input  logic              dt_we,
    input  logic [WORDS-1:0]  dt_new
);
    line_st_e         st_q [NUM_SLOTS];
    logic [WORDS-1:0] dt_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!rst_n) begin
                st_q[i] <= LN_HW_INV;
                dt_q[i] <= '0;
            end else if (wr_slot == SLOT_W'(i)) begin
                if (st_we) st_q[i] <= st_new;
                if (dt_we) dt_q[i] <= dt_new;
            end
        end
    end

    assign rd_state = st_q[rd_slot];
    assign rd_dirty = dt_q[rd_slot];
endmodule

// File: rtl/hcoh_ctrl.sv
module hcoh_ctrl
    import hcoh_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int SLOT_W = 2,
    parameter int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  core_op_e          req_op,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [WORD_W-1:0] req_word,
    input  logic              dom_sw,
    input  line_st_e          cur_st,
    input  logic [WORDS-1:0]  cur_dirty,
    input  logic              dir_gnt,
    output logic              req_ready,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic              dir_valid,
    output dir_op_e           dir_op,
    output logic              wb_valid,
    output logic [WORDS-1:0]  wb_mask,
    output logic [SLOT_W-1:0] wr_slot,
    output logic              st_we,
    output line_st_e          st_new,
    output logic              dt_we,
    output logic [WORDS-1:0]  dt_new
);
    typedef enum logic [1:0] {
        FSM_IDLE      = 2'd0,
        FSM_WAIT_FILL = 2'd1,
        FSM_WAIT_REL  = 2'd2
    } fsm_e;

    fsm_e              fsm_q, fsm_d;
    line_st_e          pend_st_q, pend_st_d;
    logic [SLOT_W-1:0] pend_slot_q, pend_slot_d;
    logic [WORDS-1:0]  word_bit;

    assign word_bit = WORDS'(1) << req_word;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= FSM_IDLE;
            pend_st_q   <= LN_HW_INV;
            pend_slot_q <= '0;
        end else begin
            fsm_q       <= fsm_d;
            pend_st_q   <= pend_st_d;
            pend_slot_q <= pend_slot_d;
        end
    end

    // Next state and outputs
    always_comb begin
        fsm_d       = fsm_q;
        pend_st_d   = pend_st_q;
        pend_slot_d = pend_slot_q;
        req_ready   = 1'b0;
        rsp_hit     = 1'b0;
        rsp_err     = 1'b0;
        dir_valid   = 1'b0;
        dir_op      = DIR_RDREQ;
        wb_valid    = 1'b0;
        wb_mask     = '0;
        wr_slot     = req_slot;
        st_we       = 1'b0;
        st_new      = cur_st;
        dt_we       = 1'b0;
        dt_new      = cur_dirty;
        unique case (fsm_q)
            FSM_IDLE: begin
                if (req_valid) begin
                    pend_slot_d = req_slot;
                    if (dom_sw && !in_sw_domain(cur_st)) begin
                        // hardware -> software: release first
                        pend_st_d = LN_SW_CLEAN;
                        unique case (cur_st)
                            LN_HW_MOD: begin
                                dir_valid = 1'b1;
                                dir_op    = DIR_WRREL;
                                fsm_d     = FSM_WAIT_REL;
                            end
                            LN_HW_SHR: begin
                                dir_valid = 1'b1;
                                dir_op    = DIR_RDREL;
                                fsm_d     = FSM_WAIT_REL;
                            end
                            default: begin
                                st_we  = 1'b1;
                                st_new = LN_SW_CLEAN;
                            end
                        endcase
                    end else if (!dom_sw && in_sw_domain(cur_st)) begin
                        // software -> hardware: flush dirty words, then release
                        dir_valid = 1'b1;
                        dir_op    = DIR_RDREL;
                        wb_valid  = (cur_st == LN_SW_PDRT);
                        wb_mask   = (cur_st == LN_SW_PDRT) ? cur_dirty : '0;
                        dt_we     = 1'b1;
                        dt_new    = '0;
                        pend_st_d = LN_HW_INV;
                        fsm_d     = FSM_WAIT_REL;
                    end else if (!dom_sw) begin
                        unique case (req_op)
                            OP_LOAD, OP_LOAD_RO: begin
                                if (cur_st == LN_HW_INV) begin
                                    dir_valid = 1'b1;
                                    dir_op    = DIR_RDREQ;
                                    pend_st_d = LN_HW_SHR;
                                    fsm_d     = FSM_WAIT_FILL;
                                end else begin
                                    req_ready = 1'b1;
                                    rsp_hit   = 1'b1;
                                end
                            end
                            OP_STORE: begin
                                if (cur_st == LN_HW_MOD) begin
                                    req_ready = 1'b1;
                                    rsp_hit   = 1'b1;
                                end else begin
                                    dir_valid = 1'b1;
                                    dir_op    = DIR_WRREQ;
                                    pend_st_d = LN_HW_MOD;
                                    fsm_d     = FSM_WAIT_FILL;
                                end
                            end
                            default: req_ready = 1'b1;
                        endcase
                    end else begin
                        req_ready = 1'b1;
                        unique case (req_op)
                            OP_LOAD: begin
                                if (cur_st == LN_SW_CLEAN) begin
                                    st_we  = 1'b1;
                                    st_new = LN_SW_PCLN;
                                end else begin
                                    rsp_hit = 1'b1;
                                end
                            end
                            OP_LOAD_RO: begin
                                if (cur_st == LN_SW_CLEAN) begin
                                    st_we  = 1'b1;
                                    st_new = LN_SW_IMM;
                                end else begin
                                    rsp_hit = 1'b1;
                                end
                            end
                            OP_STORE: begin
                                if (cur_st == LN_SW_IMM) begin
                                    rsp_err = 1'b1;
                                end else begin
                                    rsp_hit = (cur_st != LN_SW_CLEAN);
                                    st_we   = 1'b1;
                                    st_new  = LN_SW_PDRT;
                                    dt_we   = 1'b1;
                                    dt_new  = cur_dirty | word_bit;
                                end
                            end
                            OP_INV: begin
                                st_we  = 1'b1;
                                st_new = LN_SW_CLEAN;
                                dt_we  = 1'b1;
                                dt_new = '0;
                            end
                            OP_FLUSH: begin
                                if (cur_st == LN_SW_PDRT) begin
                                    wb_valid = 1'b1;
                                    wb_mask  = cur_dirty;
                                    st_we    = 1'b1;
                                    st_new   = LN_SW_CLEAN;
                                    dt_we    = 1'b1;
                                    dt_new   = '0;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
            FSM_WAIT_FILL, FSM_WAIT_REL: begin
                wr_slot = pend_slot_q;
                if (dir_gnt) begin
                    st_we     = 1'b1;
                    st_new    = pend_st_q;
                    req_ready = (fsm_q == FSM_WAIT_FILL);
                    fsm_d     = FSM_IDLE;
                end
            end
            default: fsm_d = FSM_IDLE;
        endcase
    end
endmodule

// File: rtl/hybrid_coh_ctrl.sv
module hybrid_coh_ctrl
    import hcoh_pkg::*;
#(
    parameter  int NUM_SLOTS   = 4,
    parameter  int WORDS       = 4,
    parameter  int NUM_REGIONS = 16,
    localparam int SLOT_W      = $clog2(NUM_SLOTS),
    localparam int WORD_W      = $clog2(WORDS),
    localparam int REG_W       = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [REG_W-1:0]  req_region,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ready,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic              dir_valid,
    output logic [1:0]        dir_op,
    input  logic              dir_gnt,
    output logic [SLOT_W-1:0] msg_slot,
    output logic              wb_valid,
    output logic [WORDS-1:0]  wb_mask,
    input  logic              tbl_we,
    input  logic [REG_W-1:0]  tbl_idx,
    input  logic              tbl_sw
);
    logic              dom_sw;
    line_st_e          cur_st, st_new;
    logic [WORDS-1:0]  cur_dirty, dt_new;
    logic              st_we, dt_we;
    logic [SLOT_W-1:0] wr_slot;
    dir_op_e           dir_op_t;

    hcoh_region_tbl #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(REG_W)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_we),
        .wr_idx (tbl_idx),
        .wr_sw  (tbl_sw),
        .rd_idx (req_region),
        .rd_sw  (dom_sw)
    );

    hcoh_line_store #(.NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .SLOT_W(SLOT_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_slot  (req_slot),
        .rd_state (cur_st),
        .rd_dirty (cur_dirty),
        .wr_slot  (wr_slot),
        .st_we    (st_we),
        .st_new   (st_new),
        .dt_we    (dt_we),
        .dt_new   (dt_new)
    );

    hcoh_ctrl #(.WORDS(WORDS), .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (core_op_e'(req_op)),
        .req_slot  (req_slot),
        .req_word  (req_word),
        .dom_sw    (dom_sw),
        .cur_st    (cur_st),
        .cur_dirty (cur_dirty),
        .dir_gnt   (dir_gnt),
        .req_ready (req_ready),
        .rsp_hit   (rsp_hit),
        .rsp_err   (rsp_err),
        .dir_valid (dir_valid),
        .dir_op    (dir_op_t),
        .wb_valid  (wb_valid),
        .wb_mask   (wb_mask),
        .wr_slot   (wr_slot),
        .st_we     (st_we),
        .st_new    (st_new),
        .dt_we     (dt_we),
        .dt_new    (dt_new)
    );

    assign dir_op   = dir_op_t;
    assign msg_slot = wr_slot;
endmodule

// File: rtl/hybrid_coh_ctrl_chk.sv
module hybrid_coh_ctrl_chk #(
    parameter int WORDS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic             req_ready,
    input logic             rsp_hit,
    input logic             rsp_err,
    input logic             dir_valid,
    input logic [1:0]       dir_op,
    input logic             dir_gnt,
    input logic             wb_valid,
    input logic [WORDS-1:0] wb_mask
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         outst_q <= 1'b0;
        else if (dir_valid) outst_q <= 1'b1;
        else if (dir_gnt)   outst_q <= 1'b0;
    end

    p_single_msg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q |-> !dir_valid);

    p_stall_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (outst_q && !dir_gnt) |-> !req_ready);

    p_hit_completes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (req_ready && !rsp_err));

    p_err_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (req_ready && req_op == 3'd2 && !dir_valid && !wb_valid));

    p_wb_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_mask != '0));

    p_wb_with_rdrel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && dir_valid) |-> (dir_op == 2'd3));

    p_swcmd_no_msg_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 3'd3 || req_op == 3'd4)) |-> !dir_valid);
endmodule

bind hybrid_coh_ctrl hybrid_coh_ctrl_chk #(.WORDS(WORDS)) u_chk (.*);

// File: tb/hybrid_coh_ctrl_tb_top.sv
module hybrid_coh_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [3:0] req_region = '0;
    logic [1:0] req_slot = '0;
    logic [1:0] req_word = '0;
    logic       req_ready, rsp_hit, rsp_err, dir_valid, wb_valid;
    logic [1:0] dir_op;
    logic       dir_gnt = 1'b0;
    logic [1:0] msg_slot;
    logic [3:0] wb_mask;
    logic       tbl_we = 1'b0;
    logic [3:0] tbl_idx = '0;
    logic       tbl_sw = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model: 0 I, 1 S, 2 M, 4 clean, 5 immutable, 6 priv-clean, 7 priv-dirty
    int       m_st [4];
    bit [3:0] m_dt [4];
    bit       m_tbl [16];

    always #10 clk = ~clk;

    hybrid_coh_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_region(req_region), .req_slot(req_slot), .req_word(req_word),
        .req_ready(req_ready), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
        .dir_valid(dir_valid), .dir_op(dir_op), .dir_gnt(dir_gnt),
        .msg_slot(msg_slot), .wb_valid(wb_valid), .wb_mask(wb_mask),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_sw(tbl_sw)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic tbl_write(input int idx, input bit sw);
        tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_sw = sw;
        @(negedge clk);
        tbl_we = 1'b0;
        m_tbl[idx] = sw;
    endtask

    task automatic predict(input int op, input int slot, input int word,
                           output int nd, output int o0, output int o1, output int wbm,
                           output bit hit, output bit err, output string tag);
        int s;
        bit sw;
        bit [3:0] d;
        s = m_st[slot]; d = m_dt[slot]; sw = m_tbl[slot & 1];
        nd = 0; o0 = -1; o1 = -1; wbm = 0; hit = 0; err = 0; tag = "";
        if (sw && s < 4) begin
            tag = "R9";
            if (s == 2) begin o0 = 2; nd = 1; end
            else if (s == 1) begin o0 = 3; nd = 1; end
            s = 4;
        end else if (!sw && s >= 4) begin
            tag = "R10";
            if (s == 7) wbm = int'(d);
            o0 = 3; nd = 1; s = 0; d = '0;
        end
        if (!sw) begin
            if (op == 0 || op == 1) begin
                if (tag == "") tag = "R2";
                if (s == 0) begin
                    if (nd == 0) o0 = 0; else o1 = 0;
                    nd++; s = 1;
                end else hit = 1;
            end else if (op == 2) begin
                if (tag == "") tag = "R3";
                if (s == 2) hit = 1;
                else begin
                    if (nd == 0) o0 = 1; else o1 = 1;
                    nd++; s = 2;
                end
            end else if (tag == "") tag = "R12";
        end else begin
            case (op)
                0: begin if (tag == "") tag = "R5"; if (s == 4) s = 6; else hit = 1; end
                1: begin if (tag == "") tag = "R5"; if (s == 4) s = 5; else hit = 1; end
                2: begin
                    if (tag == "") tag = "R6";
                    if (s == 5) err = 1;
                    else begin
                        hit = (s != 4); s = 7; d[word] = 1'b1;
                    end
                end
                3: begin if (tag == "") tag = "R8"; s = 4; d = '0; end
                default: begin
                    if (tag == "") tag = "R7";
                    if (s == 7) begin wbm = int'(d); s = 4; d = '0; end
                end
            endcase
        end
        m_st[slot] = s; m_dt[slot] = d;
    endtask

    task automatic run_access(input int op, input int slot, input int word,
                              output int nd, output int o0, output int o1, output int wbm,
                              output bit hit, output bit err);
        int  wait_cnt;
        int  guard;
        bit  done;
        wait_cnt = 0; guard = 0; done = 0;
        nd = 0; o0 = -1; o1 = -1; wbm = 0; hit = 0; err = 0;
        req_valid = 1'b1; req_op = 3'(op); req_slot = 2'(slot);
        req_word = 2'(word); req_region = 4'(slot & 1);
        while (!done) begin
            dir_gnt = (wait_cnt == 1);
            if (wait_cnt > 0) wait_cnt--;
            #2;
            if (wait_cnt > 0 && !dir_gnt) begin
                check(!req_ready && !dir_valid, "R4", "stall while message outstanding",
                      int'(req_ready | dir_valid), 0);
            end
            if (dir_valid) begin
                if (nd == 0) o0 = int'(dir_op); else o1 = int'(dir_op);
                nd++;
                wait_cnt = 2;
            end
            if (wb_valid) wbm = int'(wb_mask);
            if (req_ready) begin
                hit = rsp_hit; err = rsp_err; done = 1;
            end
            guard++;
            if (guard > 40) begin
                check(1'b0, "R4", "request never completed", guard, 40);
                done = 1;
            end
            @(negedge clk);
        end
        req_valid = 1'b0; dir_gnt = 1'b0;
    endtask

    task automatic access_cmp(input int op, input int slot, input int word,
                              output int a_nd, output int a_o0, output int a_o1,
                              output int a_wb);
        int e_nd, e_o0, e_o1, e_wb;
        bit e_hit, e_err, a_hit, a_err;
        string tag;
        predict(op, slot, word, e_nd, e_o0, e_o1, e_wb, e_hit, e_err, tag);
        run_access(op, slot, word, a_nd, a_o0, a_o1, a_wb, a_hit, a_err);
        check(a_nd == e_nd, tag, "message count", a_nd, e_nd);
        check(a_o0 == e_o0, tag, "first dir_op", a_o0, e_o0);
        check(a_o1 == e_o1, tag, "second dir_op", a_o1, e_o1);
        check(a_wb == e_wb, tag, "wb_mask", a_wb, e_wb);
        check(a_hit == e_hit, tag, "rsp_hit", int'(a_hit), int'(e_hit));
        check(a_err == e_err, tag, "rsp_err", int'(a_err), int'(e_err));
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        check(1'b0, "R4", "watchdog expired", 150000, 0);
        finish_run();
    end

    initial begin
        int nd, o0, o1, wb;
        bit [15:0] lfsr;
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_dt[i] = '0; end
        for (int i = 0; i < 16; i++) m_tbl[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!dir_valid && !wb_valid && !req_ready, "R1", "idle outputs after reset",
              int'({dir_valid, wb_valid, req_ready}), 0);
        @(negedge clk);

        access_cmp(0, 0, 0, nd, o0, o1, wb);
        check(o0 == 0, "R1", "first load gives read request", o0, 0);
        access_cmp(2, 0, 1, nd, o0, o1, wb);           // S -> M
        tbl_write(0, 1'b1);
        access_cmp(0, 0, 0, nd, o0, o1, wb);           // M released, then load
        check(o0 == 2, "R9", "modified line write release", o0, 2);
        access_cmp(2, 0, 0, nd, o0, o1, wb);
        access_cmp(2, 0, 2, nd, o0, o1, wb);
        access_cmp(4, 0, 0, nd, o0, o1, wb);
        check(wb == 5, "R7", "flush writes words 0 and 2", wb, 5);
        access_cmp(2, 0, 1, nd, o0, o1, wb);
        access_cmp(2, 0, 3, nd, o0, o1, wb);
        tbl_write(0, 1'b0);
        access_cmp(0, 0, 0, nd, o0, o1, wb);
        check(wb == 10 && nd == 2, "R10", "dirty write-back with release and refill",
              wb * 10 + nd, 102);
        tbl_write(1, 1'b1);
        access_cmp(0, 1, 0, nd, o0, o1, wb);
        check(nd == 0, "R11", "table write seen on next request", nd, 0);
        access_cmp(3, 1, 0, nd, o0, o1, wb);
        access_cmp(1, 1, 0, nd, o0, o1, wb);
        access_cmp(2, 1, 3, nd, o0, o1, wb);           // immutable store error
        access_cmp(3, 0, 0, nd, o0, o1, wb);           // hw-domain invalidate
        access_cmp(4, 0, 0, nd, o0, o1, wb);           // hw-domain flush

        lfsr = 16'hACE1;
        for (int it = 0; it < 1500; it++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) begin
                tbl_write(int'(lfsr[3]), lfsr[4]);
            end else begin
                access_cmp(int'(lfsr[7:5]) % 5, int'(lfsr[9:8]), int'(lfsr[11:10]),
                           nd, o0, o1, wb);
            end
        end
        finish_run();
    end
endmodule